// File: doc/BRIEF.md
# Nibble SEC-DED Hamming Codec

This block protects a 4-bit data word with a modified Hamming code of eight bits. Three parity bits overlap the data bits, and an overall parity bit covers the other seven. The encoder side turns a nibble into a codeword. The decoder side takes any received 8-bit word and returns the repaired nibble. It also returns the raw syndrome and three exclusive status flags: single error repaired, double error seen, and error in the overall parity bit only.

Codeword bit `i-1` holds code position `i` for positions 1 to 7, and bit 7 holds the overall parity bit. Because the parity bits sit at the power-of-two positions, a nonzero syndrome read as a binary number names the failing position directly. A parameter chooses whether all outputs pass through a register stage (the default) or come straight from the logic.

Top module: `secded_nib_codec`

## Requirements
- R1: The encoder places data bits d3, d2, d1, d0 at codeword bits 6, 5, 4 and 2.
- R2: The encoder sets codeword bit 3 to d1^d2^d3, bit 1 to d0^d2^d3 and bit 0 to d0^d1^d3, so every group has even parity.
- R3: Codeword bit 7 is the XOR of codeword bits 6 to 0, so the full word has even parity.
- R4: The decoder syndrome is {c2,c1,c0}. Here c2 is the XOR of bits 3,4,5,6, c1 is the XOR of bits 1,2,5,6, and c0 is the XOR of bits 0,2,4,6. For any valid codeword it is zero.
- R5: Inverting one bit at position p (codeword bit p-1, p from 1 to 7) gives syndrome p and raises sglFixed. The decoded data equals the original nibble.
- R6: Inverting only bit 7 gives syndrome 0 and raises ovrErr. The decoded data equals the original nibble.
- R7: Inverting two distinct bits gives a nonzero syndrome and raises dblErr. No bit is corrected, so decData equals received bits {6,5,4,2}.
- R8: A valid codeword raises no flag, and decData equals its data bits in d3..d0 order.
- R9: At most one of sglFixed, dblErr and ovrErr is high at any time.
- R10: With REG_OUT=1, every output appears one clock after its input. While rstN is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| encData | input | 4 | Nibble to encode, d3..d0 |
| encWord | output | 8 | Encoded codeword |
| rxWord | input | 8 | Received codeword to decode |
| decData | output | 4 | Corrected nibble, d3..d0 |
| decSyndrome | output | 3 | Syndrome {c2,c1,c0} |
| sglFixed | output | 1 | A single error was found and repaired |
| dblErr | output | 1 | A double error was found; no repair was made |
| ovrErr | output | 1 | Only the overall parity bit was wrong |

## Verification
In the default configuration, every encoder and decoder result is due exactly one rising edge after its input. The bench changes inputs on the falling edge. It then waits for the next rising edge and samples 1 ns later, so each comparison sees the registered answer to exactly one stimulus. Expected codewords, syndromes and flags come from bench functions built from the parity equations. A seeded random mix of clean words, single flips and double flips runs alongside directed cases: the worked 0101 example, every single position, and the overall bit alone.

// File: rtl/secded_nib_pkg.sv
package secded_nib_pkg;
  localparam int DATA_W = 4;
  localparam int SYN_W  = 3;
  localparam int HAM_W  = (1 << SYN_W) - 1;
  localparam int CW_W   = HAM_W + 1;

  typedef struct packed {
    logic doFlip;
    logic sgl;
    logic dbl;
    logic ovr;
  } dec_strobe_t;

  function automatic logic isPow2(input int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // spread the nibble over the non power-of-two positions, lowest first
  function automatic logic [HAM_W-1:0] placeData(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int pos = 1; pos <= HAM_W; pos++) begin
      if (!isPow2(pos) && k < DATA_W) begin
        w[pos-1] = d[k];
        k++;
      end
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pickData(input logic [HAM_W-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= HAM_W; pos++) begin
      if (!isPow2(pos) && k < DATA_W) begin
        d[k] = w[pos-1];
        k++;
      end
    end
    return d;
  endfunction

  // syndrome bit k: XOR of every position whose index has bit k set
  function automatic logic [SYN_W-1:0] synOf(input logic [HAM_W-1:0] w);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int k = 0; k < SYN_W; k++)
      for (int pos = 1; pos <= HAM_W; pos++)
        if (((pos >> k) & 1) == 1) s[k] = s[k] ^ w[pos-1];
    return s;
  endfunction
endpackage

// File: rtl/secded_nib_enc.sv
module secded_nib_enc
  import secded_nib_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CW_W-1:0]   wordOut
);
  logic [HAM_W-1:0] bare;
  logic [SYN_W-1:0] parBits;
  logic [HAM_W-1:0] ham;

  assign bare    = placeData(dataIn);
  assign parBits = synOf(bare);

  genvar gk;
  generate
    for (gk = 1; gk <= HAM_W; gk++) begin : g_pos
      if (isPow2(gk)) begin : g_par
        assign ham[gk-1] = parBits[$clog2(gk)];
      end else begin : g_dat
        assign ham[gk-1] = bare[gk-1];
      end
    end
  endgenerate

  assign wordOut = {^ham, ham};

  // R4: a freshly built codeword checks clean and keeps its data
  p_enc_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    (synOf(wordOut[HAM_W-1:0]) == '0) && (pickData(wordOut[HAM_W-1:0]) == dataIn));
  // R3: full word has even parity
  p_enc_even_r3: assert property (@(posedge clk) disable iff (!rstN)
    (^wordOut) == 1'b0);
endmodule

// File: rtl/secded_nib_dec_dp.sv
module secded_nib_dec_dp
  import secded_nib_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW_W-1:0]   rxWord,
  input  dec_strobe_t       strobe,
  output logic [SYN_W-1:0]  syndrome,
  output logic              allFail,
  output logic [DATA_W-1:0] dataOut
);
  logic [HAM_W-1:0] flipMask;
  logic [HAM_W-1:0] fixedHam;

  assign syndrome = synOf(rxWord[HAM_W-1:0]);
  assign allFail  = ^rxWord;

  genvar gp;
  generate
    for (gp = 1; gp <= HAM_W; gp++) begin : g_mask
      assign flipMask[gp-1] = strobe.doFlip && (syndrome == SYN_W'(gp));
    end
  endgenerate

  assign fixedHam = rxWord[HAM_W-1:0] ^ flipMask;
  assign dataOut  = pickData(fixedHam);

  // R5: after a repair the repaired word checks clean
  p_fix_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFlip |-> (synOf(fixedHam) == '0));
  // R7: without a repair the data is passed through untouched
  p_no_fix_raw_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doFlip |-> (dataOut == pickData(rxWord[HAM_W-1:0])));
endmodule

// File: rtl/secded_nib_dec_ctl.sv
module secded_nib_dec_ctl
  import secded_nib_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYN_W-1:0] syndrome,
  input  logic             allFail,
  output dec_strobe_t      strobe
);
  logic synNz;
  assign synNz = |syndrome;

  always_comb begin
    strobe = '0;
    unique case ({synNz, allFail})
      2'b11: begin strobe.sgl = 1'b1; strobe.doFlip = 1'b1; end
      2'b10: strobe.dbl = 1'b1;
      2'b01: strobe.ovr = 1'b1;
      default: strobe = '0;
    endcase
  end

  // R9: status strobes never overlap
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sgl, strobe.dbl, strobe.ovr}));
  // R7: a double report always has a nonzero syndrome
  p_dbl_syn_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dbl |-> (syndrome != '0));
  // R6: an overall-bit report always has a zero syndrome
  p_ovr_syn_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ovr |-> (syndrome == '0));
endmodule

// File: rtl/secded_nib_codec.sv
module secded_nib_codec
  import secded_nib_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  encData,
  output logic [7:0]  encWord,
  input  logic [7:0]  rxWord,
  output logic [3:0]  decData,
  output logic [2:0]  decSyndrome,
  output logic        sglFixed,
  output logic        dblErr,
  output logic        ovrErr
);
  logic [CW_W-1:0]   encNext;
  logic [SYN_W-1:0]  synNext;
  logic              allFail;
  logic [DATA_W-1:0] dataNext;
  dec_strobe_t       strobe;

  secded_nib_enc u_enc (
    .clk(clk), .rstN(rstN), .dataIn(encData), .wordOut(encNext)
  );

  secded_nib_dec_dp u_dp (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .strobe(strobe),
    .syndrome(synNext), .allFail(allFail), .dataOut(dataNext)
  );

  secded_nib_dec_ctl u_ctl (
    .clk(clk), .rstN(rstN), .syndrome(synNext), .allFail(allFail), .strobe(strobe)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          encWord     <= '0;
          decData     <= '0;
          decSyndrome <= '0;
          sglFixed    <= 1'b0;
          dblErr      <= 1'b0;
          ovrErr      <= 1'b0;
        end else begin
          encWord     <= encNext;
          decData     <= dataNext;
          decSyndrome <= synNext;
          sglFixed    <= strobe.sgl;
          dblErr      <= strobe.dbl;
          ovrErr      <= strobe.ovr;
        end
      end

      // R10: registered syndrome follows the previous received word
      p_lat_syn_r10: assert property (@(posedge clk) disable iff (!rstN)
        ##1 (decSyndrome == $past(synNext)));
    end else begin : g_comb
      assign encWord     = encNext;
      assign decData     = dataNext;
      assign decSyndrome = synNext;
      assign sglFixed    = strobe.sgl;
      assign dblErr      = strobe.dbl;
      assign ovrErr      = strobe.ovr;
    end
  endgenerate

  // R9: port flags stay mutually exclusive
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sglFixed, dblErr, ovrErr}));
endmodule

// File: tb/secded_nib_codec_tb.sv
module secded_nib_codec_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] encData = '0;
  logic [7:0] encWord;
  logic [7:0] rxWord = '0;
  logic [3:0] decData;
  logic [2:0] decSyndrome;
  logic       sglFixed, dblErr, ovrErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  secded_nib_codec u_dut (
    .clk(clk), .rstN(rstN), .encData(encData), .encWord(encWord),
    .rxWord(rxWord), .decData(decData), .decSyndrome(decSyndrome),
    .sglFixed(sglFixed), .dblErr(dblErr), .ovrErr(ovrErr)
  );

  // reference encoder written from the parity equations
  function automatic logic [7:0] refEnc(input logic [3:0] d);
    logic [6:0] w;
    w[6] = d[3]; w[5] = d[2]; w[4] = d[1]; w[2] = d[0];
    w[3] = d[1] ^ d[2] ^ d[3];
    w[1] = d[0] ^ d[2] ^ d[3];
    w[0] = d[0] ^ d[1] ^ d[3];
    return {^w, w};
  endfunction

  function automatic logic [2:0] refSyn(input logic [7:0] w);
    return {w[3]^w[4]^w[5]^w[6], w[1]^w[2]^w[5]^w[6], w[0]^w[2]^w[4]^w[6]};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic apply(input logic [3:0] d, input logic [7:0] flip);
    @(negedge clk);
    encData = d;
    rxWord  = refEnc(d) ^ flip;
    @(posedge clk);
    #1;
  endtask

  task automatic checkDecode(input logic [3:0] d, input logic [7:0] flip);
    int nFlip;
    logic [7:0] rx;
    rx = refEnc(d) ^ flip;
    nFlip = $countones(flip);
    chk("R1 R2 R3 encode", encWord, refEnc(d));
    chk("R4 syndrome", {5'b0, decSyndrome}, {5'b0, refSyn(rx)});
    if (nFlip == 0) begin
      chk("R8 clean flags", {5'b0, sglFixed, dblErr, ovrErr}, 8'h00);
      chk("R8 clean data", {4'b0, decData}, {4'b0, d});
    end else if (nFlip == 1 && flip[7]) begin
      chk("R6 overall flags", {5'b0, sglFixed, dblErr, ovrErr}, 8'h01);
      chk("R6 overall data", {4'b0, decData}, {4'b0, d});
    end else if (nFlip == 1) begin
      chk("R5 single flags", {5'b0, sglFixed, dblErr, ovrErr}, 8'h04);
      chk("R5 single data", {4'b0, decData}, {4'b0, d});
    end else begin
      chk("R7 double flags", {5'b0, sglFixed, dblErr, ovrErr}, 8'h02);
      chk("R7 double data", {4'b0, decData}, {4'b0, rx[6], rx[5], rx[4], rx[2]});
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EC0DE;
    void'($urandom(seed));

    // R10: outputs held at zero during reset despite active inputs
    encData = 4'hF;
    rxWord  = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset encWord", encWord, 8'h00);
    chk("R10 reset dec", {decData, decSyndrome, sglFixed}, 8'h00);
    chk("R10 reset flags", {6'b0, dblErr, ovrErr}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 worked example: 0101 -> 0101101, overall 0
    apply(4'b0101, 8'h00);
    chk("R2 example word", encWord, 8'h2D);
    checkDecode(4'b0101, 8'h00);
    apply(4'b0101, 8'h04);
    chk("R5 example syndrome", {5'b0, decSyndrome}, 8'd3);
    checkDecode(4'b0101, 8'h04);

    // R5: every single position names itself
    for (int p = 1; p <= 7; p++) begin
      apply(4'b1011, 8'(1 << (p - 1)));
      chk("R5 position", {5'b0, decSyndrome}, 8'(p));
      checkDecode(4'b1011, 8'(1 << (p - 1)));
    end

    // R6: overall bit alone
    apply(4'b1110, 8'h80);
    chk("R6 syndrome zero", {5'b0, decSyndrome}, 8'h00);
    checkDecode(4'b1110, 8'h80);

    // R7: double including overall bit, and two data bits
    apply(4'b0011, 8'h81);
    checkDecode(4'b0011, 8'h81);
    apply(4'b0000, 8'h44);
    checkDecode(4'b0000, 8'h44);

    // R10: latency — change input, old answer gone after one edge
    apply(4'hA, 8'h00);
    apply(4'h5, 8'h00);
    chk("R10 one-cycle latency", encWord, refEnc(4'h5));

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] d;
      logic [7:0] fl;
      int mode, a, b;
      d = 4'($urandom);
      mode = int'($urandom % 3);
      a = int'($urandom % 8);
      b = (a + 1 + int'($urandom % 7)) % 8;
      case (mode)
        0: fl = 8'h00;
        1: fl = 8'(1 << a);
        default: fl = 8'(1 << a) | 8'(1 << b);
      endcase
      apply(d, fl);
      checkDecode(d, fl);
      // R9: at most one flag
      chk("R9 flags exclusive", {7'b0, ($countones({sglFixed, dblErr, ovrErr}) > 1)}, 8'h00);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule